// File: doc/BRIEF.md
# Multi-Size LRU Stack Hit Tracker

This block is a fully associative tag store of `ENTRIES` slots held in strict recency order. Each slot carries a rank register, where rank 0 is the most recently used slot and rank `ENTRIES-1` is the least recently used. Each slot also carries a membership mask. Bit i of the mask says whether the slot would still be resident in a smaller fully associative LRU cache of `MIN_BLOCKS·2^i` blocks. A single stream of lookups therefore yields hit and miss counts for every power-of-two capacity from `MIN_BLOCKS` up to the full store. The number of tracked smaller capacities is T = log2(ENTRIES) − log2(MIN_BLOCKS) when ENTRIES > MIN_BLOCKS, and zero otherwise. At most 32 are allowed.

The masks are not recomputed from scratch. They move incrementally, and the rule that each capacity boundary obeys is simple. When a slot is promoted to MRU, every capacity that did not hold that slot pushes its boundary slot out: that slot loses its bit. When a slot is demoted to LRU, every capacity that did hold it pulls in the slot just past its boundary, and that slot gains the bit.

A two-state controller runs the block. Reset enters `ST_INIT`, which walks the slots from MRU to LRU, one per cycle, and writes each slot's starting mask. After the last slot it takes the transition `ST_INIT -> ST_RUN`. `ST_RUN` holds until the next reset and accepts these operations:

- **`OP_PROMOTE`**: a lookup hit.
- **`OP_FILL`**: the LRU slot is overwritten and promoted.
- **`OP_DEMOTE`**: an invalidate hit.
- **`OP_IDLE`**: no operation.

Top module: `lru_size_tracker`

## Requirements
- R1: While reset is held, `ready_o` is 0 and every counter is 0. After reset is released, `ready_o` rises after exactly `ENTRIES` rising clock edges.
- R2: With T tracked sizes, bit i (0 ≤ i < T) of a slot's mask is set exactly when the slot's recency position p (0 = MRU) satisfies p < `MIN_BLOCKS·2^i`. A lookup hit returns the hit slot's mask on `hit_mask_o` in the same cycle. A miss returns zero.
- R3: `hit_o` is driven combinationally in the lookup cycle and is set only for a valid slot whose tag equals `lk_tag_i`. At the next edge the hit slot becomes MRU, and every slot that was more recent moves one position older.
- R4: A fill writes `fill_tag_i` into the LRU slot, marks it valid and makes it MRU. The victim slot always has an all-zero mask. The fill tag is assumed absent from the store.
- R5: An invalidate whose tag matches a valid slot clears that slot's valid bit and moves it to the LRU position, and every older slot moves one position more recent. An invalidate with no matching tag changes nothing.
- R6: Promoting the slot that is already MRU leaves all ranks and masks unchanged. Demoting the slot that is already LRU also leaves all ranks and masks unchanged.
- R7: Each accepted lookup increments `access_cnt_o`. For each tracked size i, it increments hit counter i if the lookup hit with mask bit i set, and otherwise increments miss counter i. Counter index T counts hits and misses of the full store. Counter k sits at bits `[k·CNT_W +: CNT_W]` of `hit_cnt_o` and `miss_cnt_o`.
- R8: Counters saturate at 2^CNT_W − 1 and never wrap.
- R9: `cnt_clr_i` zeroes all counters at the next edge and takes priority over any increment in the same cycle.
- R10: A lookup, hit or miss, takes priority over a fill or invalidate in the same cycle, and the lower request is dropped. A fill takes priority over an invalidate, which is then dropped.
- R11: Lookup, fill and invalidate requests made while `ready_o` is 0 have no effect on tags, order or counters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_clr_i | input | 1 | Synchronous clear of all counters |
| lk_valid_i | input | 1 | Lookup request |
| lk_tag_i | input | TAG_W | Lookup tag |
| fill_valid_i | input | 1 | Fill request, replaces the LRU slot |
| fill_tag_i | input | TAG_W | Tag written by a fill |
| inv_valid_i | input | 1 | Invalidate request |
| inv_tag_i | input | TAG_W | Tag to invalidate and demote |
| ready_o | output | 1 | High once the initial walk has finished |
| hit_o | output | 1 | Lookup hit in the current cycle |
| hit_mask_o | output | max(T,1) | Size-membership mask of the hit slot, zero on a miss |
| hit_cnt_o | output | (T+1)·CNT_W | Per-size hit counters, full store at index T |
| miss_cnt_o | output | (T+1)·CNT_W | Per-size miss counters, full store at index T |
| access_cnt_o | output | CNT_W | Total accepted lookups |

## Verification
The embedded properties check these invariants on every cycle in `ST_RUN`:

- Every slot's stored mask agrees with the rank rule of R2, which cross-checks the incremental boundary movement against an arithmetic definition.
- Exactly one slot holds rank 0.
- A fill victim has an empty mask.
- Promoting the MRU slot disturbs nothing.
- Counters step by one, never wrap, and clear on request.

Behaviours visible only across a scenario need the bench's model of the recency list. These are the init length, request priority and dropping, invalidate of absent tags, requests during the walk, and saturation after thousands of lookups. The bench sweeps every recency position of a small 16-slot store, then runs a long pseudo-random mix of operations.

// File: rtl/lru_trk_pkg.sv
package lru_trk_pkg;

    typedef enum logic {
        ST_INIT,
        ST_RUN
    } trk_state_e;

    typedef enum logic [1:0] {
        OP_IDLE,
        OP_PROMOTE,
        OP_FILL,
        OP_DEMOTE
    } trk_op_e;

    // Number of smaller power-of-two capacities tracked below the full store.
    function automatic int tracked_sizes(input int entries, input int min_blocks);
        return (entries > min_blocks) ? ($clog2(entries) - $clog2(min_blocks)) : 0;
    endfunction

endpackage

// File: rtl/lru_sat_counter.sv
module lru_sat_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             inc_i,
    output logic [CNT_W-1:0] cnt_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr_i) begin
            cnt_q <= '0;
        end else if (inc_i && cnt_q != CNT_MAX) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign cnt_o = cnt_q;

    // R8: a counter never goes down unless cleared
    a_r8_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_i |=> (cnt_q >= $past(cnt_q)));

    // R9: clear wins over any increment
    a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (cnt_q == '0));

    // R7: one step per counted event below saturation
    a_r7_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && inc_i && cnt_q != CNT_MAX) |=> (cnt_q == $past(cnt_q) + 1'b1));

endmodule

// File: rtl/lru_tag_match.sv
module lru_tag_match #(
    parameter int ENTRIES = 16,
    parameter int TAG_W   = 16,
    parameter int IDX_W   = 4
) (
    input  logic [ENTRIES-1:0][TAG_W-1:0] tags_i,
    input  logic [ENTRIES-1:0]            valid_i,
    input  logic [TAG_W-1:0]              key_i,
    output logic                          hit_o,
    output logic [IDX_W-1:0]              idx_o
);
    logic [ENTRIES-1:0] match;

    for (genvar e = 0; e < ENTRIES; e++) begin : g_cmp
        assign match[e] = valid_i[e] && (tags_i[e] == key_i);
    end

    always_comb begin
        idx_o = '0;
        for (int e = 0; e < ENTRIES; e++) begin
            if (match[e]) begin
                idx_o = IDX_W'(e);
            end
        end
    end

    assign hit_o = |match;

endmodule

// File: rtl/lru_rank_stack.sv
module lru_rank_stack
    import lru_trk_pkg::*;
#(
    parameter int ENTRIES    = 16,
    parameter int MIN_BLOCKS = 2,
    parameter int TAG_W      = 16,
    parameter int NTRK       = 3,
    parameter int MW         = 3,
    parameter int RW         = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  trk_op_e                       op_i,
    input  logic [RW-1:0]                 tgt_i,
    input  logic [TAG_W-1:0]              fill_tag_i,
    output logic                          ready_o,
    output logic [ENTRIES-1:0][TAG_W-1:0] tags_o,
    output logic [ENTRIES-1:0]            valid_o,
    output logic [ENTRIES-1:0][MW-1:0]    masks_o,
    output logic [RW-1:0]                 lru_idx_o
);
    localparam logic [MW-1:0] ALL_TRK = (NTRK > 0) ? {MW{1'b1}} : '0;
    localparam logic [RW-1:0] LAST    = RW'(ENTRIES - 1);

    trk_state_e state_q, state_d;

    logic [ENTRIES-1:0][RW-1:0]    rank_q, rank_d;
    logic [ENTRIES-1:0][MW-1:0]    mask_q, mask_d;
    logic [ENTRIES-1:0][TAG_W-1:0] tag_q, tag_d;
    logic [ENTRIES-1:0]            valid_q, valid_d;

    logic [RW-1:0] walk_q, walk_d;
    logic [MW-1:0] run_mask_q, run_mask_d;
    logic [RW:0]   cap_q, cap_d;
    logic [5:0]    bidx_q, bidx_d;

    logic [RW-1:0] t_rank;
    logic [MW-1:0] t_mask;

    // Rank of the last slot inside capacity i.
    function automatic logic [RW-1:0] edge_rank(input int i);
        return RW'((MIN_BLOCKS << i) - 1);
    endfunction

    // Rank of the first slot outside capacity i.
    function automatic logic [RW-1:0] past_rank(input int i);
        return RW'(MIN_BLOCKS << i);
    endfunction

    assign t_rank = rank_q[tgt_i];
    assign t_mask = mask_q[tgt_i];

    // Next-state and datapath update
    always_comb begin
        state_d    = state_q;
        rank_d     = rank_q;
        mask_d     = mask_q;
        tag_d      = tag_q;
        valid_d    = valid_q;
        walk_d     = walk_q;
        run_mask_d = run_mask_q;
        cap_d      = cap_q;
        bidx_d     = bidx_q;
        unique case (state_q)
            ST_INIT: begin
                mask_d[walk_q] = run_mask_q;
                if (({1'b0, walk_q} + 1'b1) == cap_q && walk_q != LAST
                        && 32'(bidx_q) < NTRK) begin
                    run_mask_d = run_mask_q & ~(MW'(1) << bidx_q);
                    cap_d      = cap_q << 1;
                    bidx_d     = bidx_q + 1'b1;
                end
                if (walk_q == LAST) begin
                    state_d = ST_RUN;
                end else begin
                    walk_d = walk_q + 1'b1;
                end
            end
            ST_RUN: begin
                unique case (op_i)
                    OP_IDLE: begin
                    end
                    OP_PROMOTE, OP_FILL: begin
                        if (op_i == OP_FILL) begin
                            tag_d[tgt_i]   = fill_tag_i;
                            valid_d[tgt_i] = 1'b1;
                        end
                        for (int e = 0; e < ENTRIES; e++) begin
                            if (RW'(e) == tgt_i) begin
                                rank_d[e] = '0;
                                mask_d[e] = ALL_TRK;
                            end else begin
                                if (rank_q[e] < t_rank) begin
                                    rank_d[e] = rank_q[e] + 1'b1;
                                end
                                for (int i = 0; i < NTRK; i++) begin
                                    if (!t_mask[i] && rank_q[e] == edge_rank(i)) begin
                                        mask_d[e][i] = 1'b0;
                                    end
                                end
                            end
                        end
                    end
                    OP_DEMOTE: begin
                        valid_d[tgt_i] = 1'b0;
                        for (int e = 0; e < ENTRIES; e++) begin
                            if (RW'(e) == tgt_i) begin
                                rank_d[e] = LAST;
                                mask_d[e] = '0;
                            end else begin
                                if (rank_q[e] > t_rank) begin
                                    rank_d[e] = rank_q[e] - 1'b1;
                                end
                                for (int i = 0; i < NTRK; i++) begin
                                    if (t_mask[i] && rank_q[e] == past_rank(i)) begin
                                        mask_d[e][i] = 1'b1;
                                    end
                                end
                            end
                        end
                    end
                endcase
            end
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_INIT;
        end else begin
            state_q <= state_d;
        end
    end

    // Datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int e = 0; e < ENTRIES; e++) begin
                rank_q[e] <= RW'(e);
            end
            mask_q     <= '0;
            tag_q      <= '0;
            valid_q    <= '0;
            walk_q     <= '0;
            run_mask_q <= ALL_TRK;
            cap_q      <= (RW+1)'(MIN_BLOCKS);
            bidx_q     <= '0;
        end else begin
            rank_q     <= rank_d;
            mask_q     <= mask_d;
            tag_q      <= tag_d;
            valid_q    <= valid_d;
            walk_q     <= walk_d;
            run_mask_q <= run_mask_d;
            cap_q      <= cap_d;
            bidx_q     <= bidx_d;
        end
    end

    // Outputs
    always_comb begin
        ready_o   = (state_q == ST_RUN);
        tags_o    = tag_q;
        valid_o   = valid_q;
        masks_o   = mask_q;
        lru_idx_o = '0;
        for (int e = 0; e < ENTRIES; e++) begin
            if (rank_q[e] == LAST) begin
                lru_idx_o = RW'(e);
            end
        end
    end

    logic [ENTRIES-1:0] mru_vec;
    for (genvar e = 0; e < ENTRIES; e++) begin : g_mru
        assign mru_vec[e] = (rank_q[e] == '0);
    end

    // R2: incremental masks agree with the arithmetic rank rule
    for (genvar e = 0; e < ENTRIES; e++) begin : g_chk_e
        for (genvar i = 0; i < NTRK; i++) begin : g_chk_i
            a_r2_mask_rule: assert property (@(posedge clk) disable iff (!rst_n)
                (state_q == ST_RUN) |->
                (mask_q[e][i] == (32'(rank_q[e]) < (MIN_BLOCKS << i))));
        end
    end

    // R3: the recency order always has exactly one MRU slot
    a_r3_single_mru: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN) |-> ($countones(mru_vec) == 1));

    // R4: a fill victim sits at LRU and belongs to no smaller capacity
    a_r4_victim_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && op_i == OP_FILL) |->
        (mask_q[tgt_i] == '0 && rank_q[tgt_i] == LAST));

    // R6: promoting the MRU slot disturbs nothing
    a_r6_mru_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && op_i == OP_PROMOTE && rank_q[tgt_i] == '0) |=>
        ($stable(rank_q) && $stable(mask_q)));

endmodule

// File: rtl/lru_size_counters.sv
module lru_size_counters #(
    parameter int NTRK  = 3,
    parameter int MW    = 3,
    parameter int CNT_W = 32
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      clr_i,
    input  logic                      ev_i,
    input  logic                      hit_i,
    input  logic [MW-1:0]             mask_i,
    output logic [(NTRK+1)*CNT_W-1:0] hit_cnt_o,
    output logic [(NTRK+1)*CNT_W-1:0] miss_cnt_o,
    output logic [CNT_W-1:0]          acc_cnt_o
);
    for (genvar k = 0; k <= NTRK; k++) begin : g_size
        logic in_size;
        if (k < NTRK) begin : g_small
            assign in_size = hit_i && mask_i[k];
        end else begin : g_full
            assign in_size = hit_i;
        end

        lru_sat_counter #(.CNT_W(CNT_W)) u_hit (
            .clk   (clk),
            .rst_n (rst_n),
            .clr_i (clr_i),
            .inc_i (ev_i && in_size),
            .cnt_o (hit_cnt_o[k*CNT_W +: CNT_W])
        );

        lru_sat_counter #(.CNT_W(CNT_W)) u_miss (
            .clk   (clk),
            .rst_n (rst_n),
            .clr_i (clr_i),
            .inc_i (ev_i && !in_size),
            .cnt_o (miss_cnt_o[k*CNT_W +: CNT_W])
        );
    end

    lru_sat_counter #(.CNT_W(CNT_W)) u_acc (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (clr_i),
        .inc_i (ev_i),
        .cnt_o (acc_cnt_o)
    );

endmodule

// File: rtl/lru_size_tracker.sv
module lru_size_tracker
    import lru_trk_pkg::*;
#(
    parameter int ENTRIES    = 16,
    parameter int MIN_BLOCKS = 2,
    parameter int TAG_W      = 16,
    parameter int CNT_W      = 32,
    localparam int NTRK      = tracked_sizes(ENTRIES, MIN_BLOCKS),
    localparam int MW        = (NTRK > 0) ? NTRK : 1,
    localparam int RW        = $clog2(ENTRIES)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cnt_clr_i,
    input  logic                      lk_valid_i,
    input  logic [TAG_W-1:0]          lk_tag_i,
    input  logic                      fill_valid_i,
    input  logic [TAG_W-1:0]          fill_tag_i,
    input  logic                      inv_valid_i,
    input  logic [TAG_W-1:0]          inv_tag_i,
    output logic                      ready_o,
    output logic                      hit_o,
    output logic [MW-1:0]             hit_mask_o,
    output logic [(NTRK+1)*CNT_W-1:0] hit_cnt_o,
    output logic [(NTRK+1)*CNT_W-1:0] miss_cnt_o,
    output logic [CNT_W-1:0]          access_cnt_o
);
    if (NTRK > 32) begin : g_cfg_width
        $error("too many tracked capacities for a 32-bit mask");
    end
    if ((1 << RW) != ENTRIES || (MIN_BLOCKS & (MIN_BLOCKS - 1)) != 0) begin : g_cfg_pow2
        $error("entry count and minimum size must be powers of two");
    end

    logic [ENTRIES-1:0][TAG_W-1:0] tags;
    logic [ENTRIES-1:0]            valids;
    logic [ENTRIES-1:0][MW-1:0]    masks;
    logic [RW-1:0]                 lru_idx;
    logic                          lk_match, inv_match;
    logic [RW-1:0]                 lk_idx, inv_idx;
    logic                          ready;
    trk_op_e                       op;
    logic [RW-1:0]                 tgt;

    lru_tag_match #(.ENTRIES(ENTRIES), .TAG_W(TAG_W), .IDX_W(RW)) u_lk_match (
        .tags_i  (tags),
        .valid_i (valids),
        .key_i   (lk_tag_i),
        .hit_o   (lk_match),
        .idx_o   (lk_idx)
    );

    lru_tag_match #(.ENTRIES(ENTRIES), .TAG_W(TAG_W), .IDX_W(RW)) u_inv_match (
        .tags_i  (tags),
        .valid_i (valids),
        .key_i   (inv_tag_i),
        .hit_o   (inv_match),
        .idx_o   (inv_idx)
    );

    // Request arbitration: lookup, then fill, then invalidate
    always_comb begin
        op  = OP_IDLE;
        tgt = '0;
        if (ready) begin
            if (lk_valid_i) begin
                if (lk_match) begin
                    op  = OP_PROMOTE;
                    tgt = lk_idx;
                end
            end else if (fill_valid_i) begin
                op  = OP_FILL;
                tgt = lru_idx;
            end else if (inv_valid_i && inv_match) begin
                op  = OP_DEMOTE;
                tgt = inv_idx;
            end
        end
    end

    lru_rank_stack #(
        .ENTRIES    (ENTRIES),
        .MIN_BLOCKS (MIN_BLOCKS),
        .TAG_W      (TAG_W),
        .NTRK       (NTRK),
        .MW         (MW),
        .RW         (RW)
    ) u_stack (
        .clk        (clk),
        .rst_n      (rst_n),
        .op_i       (op),
        .tgt_i      (tgt),
        .fill_tag_i (fill_tag_i),
        .ready_o    (ready),
        .tags_o     (tags),
        .valid_o    (valids),
        .masks_o    (masks),
        .lru_idx_o  (lru_idx)
    );

    assign ready_o    = ready;
    assign hit_o      = ready && lk_valid_i && lk_match;
    assign hit_mask_o = hit_o ? masks[lk_idx] : '0;

    lru_size_counters #(.NTRK(NTRK), .MW(MW), .CNT_W(CNT_W)) u_counters (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr_i      (cnt_clr_i),
        .ev_i       (ready && lk_valid_i),
        .hit_i      (hit_o),
        .mask_i     (hit_mask_o),
        .hit_cnt_o  (hit_cnt_o),
        .miss_cnt_o (miss_cnt_o),
        .acc_cnt_o  (access_cnt_o)
    );

endmodule

// File: tb/tb_lru_size_tracker.sv
`timescale 1ns/1ps
module tb_lru_size_tracker;
    localparam int N    = 16;
    localparam int MINB = 2;
    localparam int TW   = 5;
    localparam int CW   = 12;
    localparam int T    = 3;
    localparam int MW   = 3;
    localparam int CMAX = (1 << CW) - 1;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic rst_n, cnt_clr, lk_valid, fill_valid, inv_valid;
    logic [TW-1:0] lk_tag, fill_tag, inv_tag;
    logic ready, hit;
    logic [MW-1:0] hit_mask;
    logic [(T+1)*CW-1:0] hit_cnt, miss_cnt;
    logic [CW-1:0] acc_cnt;

    lru_size_tracker #(.ENTRIES(N), .MIN_BLOCKS(MINB), .TAG_W(TW), .CNT_W(CW)) dut (
        .clk(clk), .rst_n(rst_n), .cnt_clr_i(cnt_clr),
        .lk_valid_i(lk_valid), .lk_tag_i(lk_tag),
        .fill_valid_i(fill_valid), .fill_tag_i(fill_tag),
        .inv_valid_i(inv_valid), .inv_tag_i(inv_tag),
        .ready_o(ready), .hit_o(hit), .hit_mask_o(hit_mask),
        .hit_cnt_o(hit_cnt), .miss_cnt_o(miss_cnt), .access_cnt_o(acc_cnt)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    logic [TW-1:0] mtag [N];
    bit            mval [N];
    int            mh [T+1];
    int            mm [T+1];
    int            ma;
    int            obs_hit;
    int            obs_mask;
    int unsigned   rs = 32'h1234_5678;

    task automatic check_eq(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int unsigned rnd();
        rs ^= rs << 13;
        rs ^= rs >> 17;
        rs ^= rs << 5;
        return rs;
    endfunction

    function automatic int find(input logic [TW-1:0] t);
        for (int p = 0; p < N; p++) begin
            if (mval[p] && mtag[p] == t) return p;
        end
        return -1;
    endfunction

    function automatic int exp_mask(input int p);
        int m = 0;
        for (int i = 0; i < T; i++) begin
            if (p < (MINB << i)) m |= (1 << i);
        end
        return m;
    endfunction

    function automatic int sat(input int x);
        return (x > CMAX) ? CMAX : x;
    endfunction

    task automatic promote(input int p);
        logic [TW-1:0] t = mtag[p];
        bit v = mval[p];
        for (int q = p; q > 0; q--) begin
            mtag[q] = mtag[q-1];
            mval[q] = mval[q-1];
        end
        mtag[0] = t;
        mval[0] = v;
    endtask

    task automatic demote(input int p);
        logic [TW-1:0] t = mtag[p];
        bit v = mval[p];
        for (int q = p; q < N-1; q++) begin
            mtag[q] = mtag[q+1];
            mval[q] = mval[q+1];
        end
        mtag[N-1] = t;
        mval[N-1] = v;
    endtask

    task automatic check_counts(input string req);
        for (int k = 0; k <= T; k++) begin
            check_eq(req, int'(hit_cnt[k*CW +: CW]), mh[k]);
            check_eq(req, int'(miss_cnt[k*CW +: CW]), mm[k]);
        end
        check_eq(req, int'(acc_cnt), ma);
    endtask

    // One cycle, entered and left at a falling edge
    task automatic step(input bit lv, input logic [TW-1:0] lt,
                        input bit fv, input logic [TW-1:0] ft,
                        input bit iv, input logic [TW-1:0] it,
                        input bit clr);
        int p;
        int q;
        int em;
        bit eh;
        lk_valid = lv; lk_tag = lt;
        fill_valid = fv; fill_tag = ft;
        inv_valid = iv; inv_tag = it;
        cnt_clr = clr;
        #1;
        check_eq("R1 ready held", int'(ready), 1);
        p  = lv ? find(lt) : -1;
        eh = (p >= 0);
        em = eh ? exp_mask(p) : 0;
        if (lv) begin
            check_eq("R3 lookup hit", int'(hit), int'(eh));
            check_eq("R2 lookup mask", int'(hit_mask), em);
        end
        obs_hit  = int'(hit);
        obs_mask = int'(hit_mask);
        if (clr) begin
            for (int k = 0; k <= T; k++) begin
                mh[k] = 0;
                mm[k] = 0;
            end
            ma = 0;
        end else if (lv) begin
            for (int k = 0; k < T; k++) begin
                if (eh && em[k]) mh[k] = sat(mh[k] + 1);
                else             mm[k] = sat(mm[k] + 1);
            end
            if (eh) mh[T] = sat(mh[T] + 1);
            else    mm[T] = sat(mm[T] + 1);
            ma = sat(ma + 1);
        end
        if (lv) begin
            if (eh) promote(p);
        end else if (fv) begin
            mtag[N-1] = ft;
            mval[N-1] = 1'b1;
            promote(N-1);
        end else if (iv) begin
            q = find(it);
            if (q >= 0) begin
                mval[q] = 1'b0;
                demote(q);
            end
        end
        @(posedge clk);
        @(negedge clk);
        lk_valid = 0; fill_valid = 0; inv_valid = 0; cnt_clr = 0;
        check_counts("R7 counters");
    endtask

    task automatic look(input logic [TW-1:0] t);
        step(1, t, 0, '0, 0, '0, 0);
    endtask

    task automatic sweep();
        for (int p = 0; p < N; p++) begin
            look(mtag[p]);
        end
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        int cyc;
        logic [TW-1:0] t;
        logic [TW-1:0] t2;
        for (int p = 0; p < N; p++) begin
            mtag[p] = '0;
            mval[p] = 1'b0;
        end
        for (int k = 0; k <= T; k++) begin
            mh[k] = 0;
            mm[k] = 0;
        end
        ma = 0;
        rst_n = 0; cnt_clr = 0;
        lk_valid = 0; fill_valid = 0; inv_valid = 0;
        lk_tag = '0; fill_tag = '0; inv_tag = '0;
        repeat (3) @(negedge clk);
        check_eq("R1 ready in reset", int'(ready), 0);
        check_counts("R1 counters in reset");

        // R11: requests during the walk must be ignored
        lk_valid = 1; lk_tag = 5'd7;
        fill_valid = 1; fill_tag = 5'd7;
        rst_n = 1;
        cyc = 0;
        while (!ready && cyc < 100) begin
            @(posedge clk);
            @(negedge clk);
            cyc++;
        end
        lk_valid = 0; fill_valid = 0;
        check_eq("R1 init length", cyc, N);
        check_counts("R11 no counts during init");
        look(5'd7);
        check_eq("R11 no fill during init", obs_hit, 0);

        // R4: fill the store, then sweep every position
        for (int k = 10; k < 26; k++) begin
            step(0, '0, 1, TW'(k), 0, '0, 0);
        end
        for (int k = 10; k < 26; k++) begin
            look(TW'(k));
            check_eq("R4 filled tag present", obs_hit, 1);
        end
        sweep();

        // R6: promote the MRU twice, demote the LRU
        t = mtag[0];
        look(t);
        look(t);
        check_eq("R6 mru repeat mask", obs_mask, 7);
        t = mtag[N-1];
        step(0, '0, 0, '0, 1, t, 0);
        sweep();
        look(t);
        check_eq("R5 invalidated tag misses", obs_hit, 0);

        // R5: absent tag then a middle slot
        step(0, '0, 0, '0, 1, 5'd31, 0);
        sweep();
        t = mtag[3];
        step(0, '0, 0, '0, 1, t, 0);
        sweep();
        look(t);
        check_eq("R5 middle invalidate misses", obs_hit, 0);

        // R10: lookup beats fill, fill beats invalidate
        step(1, mtag[5], 1, 5'd30, 0, '0, 0);
        look(5'd30);
        check_eq("R10 fill dropped under lookup", obs_hit, 0);
        t2 = mtag[2];
        step(0, '0, 1, 5'd30, 1, t2, 0);
        look(t2);
        check_eq("R10 invalidate dropped under fill", obs_hit, 1);
        look(5'd30);
        check_eq("R10 fill taken over invalidate", obs_hit, 1);

        // Long pseudo-random mix over a 32-tag space
        for (int n = 0; n < 8000; n++) begin
            int unsigned r;
            int unsigned sel;
            logic [TW-1:0] a;
            logic [TW-1:0] b;
            r = rnd();
            sel = r % 10;
            a = TW'(rnd());
            b = TW'(rnd());
            if (sel < 6) begin
                look(a);
            end else if (sel < 8) begin
                if (find(a) >= 0) look(a);
                else step(0, '0, 1, a, 0, '0, 0);
            end else if (sel == 8) begin
                step(0, '0, 0, '0, 1, a, 0);
            end else begin
                if (find(b) >= 0) step(1, a, 0, '0, 1, b, 0);
                else step(1, a, 1, b, 0, '0, 0);
            end
        end
        check_eq("R8 access saturates", int'(acc_cnt), CMAX);
        check_eq("R8 full-size miss saturates", int'(miss_cnt[T*CW +: CW]), mm[T]);

        // R9: clear wins over a same-cycle lookup
        step(1, mtag[0], 0, '0, 0, '0, 1);
        check_eq("R9 clear with lookup", int'(acc_cnt), 0);
        look(mtag[0]);
        check_eq("R9 count after clear", int'(acc_cnt), 1);

        done = 1;
        summary();
        $finish;
    end

endmodule